// File: doc/BRIEF.md
# Serial Flash Identification Front End

This block is the serial-bus slave at the edge of a flash device. It watches an active-low select, a serial clock, a data input and an active-low pause input. Each time the device is selected it collects one command byte. If that byte asks for the device identity, it streams a fixed 24-bit identifier back on the data output. Any other byte leaves the output undriven until the device is deselected. All pins are sampled by the block's own system clock, which runs several times faster than the serial clock, and serial clock edges are found by comparing consecutive samples.

The pause input freezes the transfer. While it is low, serial clock edges are discarded and the output is released, but the bit position is kept, so the transfer continues from the same place once the input returns high. Raising the select ends a transfer at any bit. A busy flag for internal write-type operations sits next to the serial logic: start and done strobes set and clear it, and nothing on the serial pins affects it.

Top module: `spi_id_responder`

## Requirements
- R1: While `cs_n` is high, the serial clock and `mosi` have no effect: `miso_oe` is 0 and no command bits are collected.
- R2: After `cs_n` falls, `mosi` is captured on each rising serial clock edge, most significant bit first. The command is decoded only after the 8th captured bit.
- R3: Command 0x9F starts identifier output. On each falling serial edge after the 8th rising edge, `DEV_ID` is shifted out most significant bit first and `miso_oe` is 1. Until the first of these falling edges, `miso_oe` stays 0.
- R4: An identifier bit on `miso` changes only on a falling serial edge. It holds steady through the rising edge that follows.
- R5: When `cs_n` goes high, `miso_oe` drops to 0 in the same system-clock cycle, at any bit of the command or the identifier. The next selection starts again from a fresh command.
- R6: While `hold_n` is 0 (with `cs_n` low), `miso_oe` is 0 and serial edges are ignored. When `hold_n` returns to 1, the command bit count or identifier bit position resumes unchanged.
- R7: `busy` is set by `op_start` and cleared by `op_done`, with `op_start` taking priority. Neither `hold_n` nor `cs_n` changes `busy`. It is 0 after reset.
- R8: Any command other than 0x9F keeps `miso_oe` at 0 for the rest of the selection.
- R9: If clocking continues after the 24th identifier bit, output wraps back to the identifier's most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low device select |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the device |
| hold_n | input | 1 | Active-low pause of serial traffic |
| op_start | input | 1 | Strobe marking the start of an internal write-type operation |
| op_done | input | 1 | Strobe marking the end of that operation |
| miso | output | 1 | Serial data out; 0 whenever not enabled |
| miso_oe | output | 1 | Output enable for the data pin (1 = drive, 0 = high impedance) |
| busy | output | 1 | Internal operation in progress |

## Verification
Two events can land in the same system-clock cycle: the pause input falling and a falling serial edge that would otherwise shift out the next identifier bit. The bench drives `hold_n` low and `sclk` low at the same moment in the middle of an identifier. It then toggles the clock while paused and releases the pause with the clock high, so the release produces no edge. The result is judged correct only if the bit that follows is exactly the one that was due when the pause arrived. A second overlap puts `op_done` and the pause together, to show that `busy` follows only its strobes.

// File: rtl/spi_id_responder.sv
module spi_id_responder #(
  parameter int CMD_W = 8,
  parameter int ID_W = 24,
  parameter logic [CMD_W-1:0] RDID_OP = 8'h9F,
  parameter logic [ID_W-1:0] DEV_ID = 24'hA53C96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic hold_n,
  input  logic op_start,
  input  logic op_done,
  output logic miso,
  output logic miso_oe,
  output logic busy
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int IDX_W = $clog2(ID_W);

  typedef enum logic [1:0] {PH_CMD, PH_ID, PH_IGN} phase_t;

  phase_t            phase;
  logic              sclk_q;
  logic [CMD_W-1:0]  cmd_sr;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              drv;
  logic              miso_q;

  wire active  = !cs_n && hold_n;
  wire rise_ev = active && sclk && !sclk_q;
  wire fall_ev = active && !sclk && sclk_q;
  wire [CMD_W-1:0] cmd_next = {cmd_sr[CMD_W-2:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      phase  <= PH_CMD;
      cmd_sr <= '0;
      cnt    <= '0;
      idx    <= '0;
      drv    <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        phase  <= PH_CMD;
        cmd_sr <= '0;
        cnt    <= '0;
        idx    <= '0;
        drv    <= 1'b0;
      end else begin
        if (phase == PH_CMD && rise_ev) begin
          cmd_sr <= cmd_next;
          cnt    <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(CMD_W - 1))
            phase <= (cmd_next == RDID_OP) ? PH_ID : PH_IGN;
        end
        if (phase == PH_ID && fall_ev) begin
          miso_q <= DEV_ID[IDX_W'(ID_W - 1) - idx];
          idx    <= (idx == IDX_W'(ID_W - 1)) ? '0 : idx + IDX_W'(1);
          drv    <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (op_start) busy <= 1'b1;
    else if (op_done)  busy <= 1'b0;
  end

  assign miso_oe = active && phase == PH_ID && drv;
  assign miso    = miso_oe & miso_q;

  assert_decode_after_full_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_CMD) |-> (cnt == CNT_W'(CMD_W)));

  assert_bit_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> $past(fall_ev));

  assert_deselect_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == PH_CMD && cnt == '0 && !drv));

  assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> ($stable(idx) && $stable(cnt) && $stable(miso_q) && $stable(phase)));

  assert_busy_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

  assert_unknown_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !miso_oe);
endmodule

// File: tb/test_spi_id_responder.sv
module test_spi_id_responder;
  localparam logic [23:0] ID = 24'hA53C96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0, hold_n = 1'b1;
  logic op_start = 1'b0, op_done = 1'b0;
  logic miso, miso_oe, busy;
  logic lo_v, lo_oe, hi_v, hi_oe;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  spi_id_responder #(.DEV_ID(ID)) i_spi_id_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .hold_n(hold_n), .op_start(op_start), .op_done(op_done),
    .miso(miso), .miso_oe(miso_oe), .busy(busy));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    mosi = b; sclk = 1'b0; tick(2);
    lo_v = miso; lo_oe = miso_oe;
    sclk = 1'b1; tick(2);
    hi_v = miso; hi_oe = miso_oe;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic select();
    cs_n = 1'b0; tick(2);
  endtask

  task automatic deselect();
    cs_n = 1'b1; tick(2);
  endtask

  task automatic read_bits(input int n, input int start, input string req);
    for (int k = 0; k < n; k++) begin
      sbit(1'b0);
      chk({req, " id bit"}, {31'd0, lo_v}, {31'd0, ID[23 - ((start + k) % 24)]});
      chk({req, " oe"}, {31'd0, lo_oe}, 32'd1);
      chk("R4 bit steady across rise", {31'd0, hi_v}, {31'd0, lo_v});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset oe", {31'd0, miso_oe}, 32'd0);
    chk("R1 reset miso", {31'd0, miso}, 32'd0);
    chk("R7 reset busy", {31'd0, busy}, 32'd0);

    // R1: clocking while deselected is ignored
    for (int i = 0; i < 16; i++) begin
      sbit(i[0]);
      chk("R1 oe while deselected", {31'd0, hi_oe}, 32'd0);
    end
    select();
    send_byte(8'h9F);
    chk("R3 oe low before first fall", {31'd0, hi_oe}, 32'd0);
    read_bits(24, 0, "R1 after ignored clocks");
    deselect();

    // R2 R3 R8: sweep every command byte
    for (int op = 0; op < 256; op++) begin
      select();
      send_byte(op[7:0]);
      if (op == 'h9F) begin
        read_bits(6, 0, "R3 sweep");
      end else begin
        for (int k = 0; k < 6; k++) begin
          sbit(1'b1);
          chk("R8 unknown op oe", {31'd0, lo_oe | hi_oe}, 32'd0);
          chk("R2 unknown op miso", {31'd0, lo_v | hi_v}, 32'd0);
        end
      end
      deselect();
    end

    // R9: wrap past 24 bits
    select();
    send_byte(8'h9F);
    read_bits(40, 0, "R9 wrap");
    deselect();

    // R5: deselect mid identifier, then mid command
    select();
    send_byte(8'h9F);
    read_bits(5, 0, "R5 pre");
    cs_n = 1'b1; #1;
    chk("R5 oe drops at once", {31'd0, miso_oe}, 32'd0);
    tick(2);
    select();
    send_byte(8'h9F);
    read_bits(8, 0, "R5 restart");
    deselect();
    select();
    for (int i = 0; i < 4; i++) sbit(1'b1);
    deselect();
    select();
    send_byte(8'h9F);
    read_bits(4, 0, "R5 after partial command");
    deselect();

    // R6: hold during command phase
    select();
    for (int i = 7; i >= 4; i--) sbit(8'h9F >> i);
    hold_n = 1'b0; tick(2);
    for (int i = 0; i < 3; i++) sbit(1'b0);
    hold_n = 1'b1; tick(2);
    for (int i = 3; i >= 0; i--) sbit(8'h9F >> i);
    read_bits(6, 0, "R6 hold in command");

    // R6: hold falls together with a falling serial edge
    hold_n = 1'b0; sclk = 1'b0; tick(2);
    chk("R6 oe during hold", {31'd0, miso_oe}, 32'd0);
    chk("R6 miso during hold", {31'd0, miso}, 32'd0);
    sclk = 1'b1; tick(2);
    sclk = 1'b0; tick(2);
    sclk = 1'b1; tick(2);
    chk("R6 oe still held", {31'd0, miso_oe}, 32'd0);
    hold_n = 1'b1; tick(2);
    read_bits(10, 6, "R6 resume");

    // R7: busy unaffected by hold or select
    op_start = 1'b1; tick(1); op_start = 1'b0; tick(1);
    chk("R7 busy set", {31'd0, busy}, 32'd1);
    hold_n = 1'b0; tick(4);
    chk("R7 busy during hold", {31'd0, busy}, 32'd1);
    deselect();
    chk("R7 busy after deselect", {31'd0, busy}, 32'd1);
    select();
    op_done = 1'b1; tick(1); op_done = 1'b0; tick(1);
    chk("R7 busy cleared by done under hold", {31'd0, busy}, 32'd0);
    op_start = 1'b1; op_done = 1'b1; tick(1);
    op_start = 1'b0; op_done = 1'b0; tick(1);
    chk("R7 start wins over done", {31'd0, busy}, 32'd1);
    op_done = 1'b1; tick(1); op_done = 1'b0; tick(1);
    chk("R7 busy cleared", {31'd0, busy}, 32'd0);
    hold_n = 1'b1;
    deselect();

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule